// File: doc/BRIEF.md
# Suspend Duty Modulator

The block throttles a processor core by pulsing an active-low suspend request. It alternates between an idle phase, in which the request is asserted and the core stops, and a run phase, in which the request is released. Each phase length is set by its own 8-bit count of base ticks. A free-running prescaler produces one base tick every `TICK_DIV` clocks; the default gives 32 µs at 200 MHz. The fraction of time the core runs is therefore RUN / (RUN + IDLE).

Two speedup sources can pause throttling: an interrupt event and a video activity event. When its enable bit is set, an event reloads that source's 8-bit hold timer. The timer counts coarse units of `UNIT_TICKS` base ticks, which is about 1 ms by default. While either timer is non-zero the suspend request stays released. When both timers reach zero, modulation restarts with a run phase.

A byte-wide register port holds the phase counts, the enable bits and the hold-timer reload values. Software writes a register with `wr_en`, and `rd_data` always shows the register selected by `addr`.

Top module: `susp_duty_mod`

## Requirements
- R1: After reset every register reads 0x00 and `susp_n` is 1.
- R2: The register port uses these addresses. 0x80 is the power control register: bit 0 is the global enable, bit 3 enables interrupt speedup and bit 4 enables video speedup. Its other bits always read 0, so writing 0xFF reads back 0x19. 0x8C holds the interrupt hold reload and 0x8D the video hold reload. 0x94 holds the run (released) count and 0x95 the idle (asserted) count. At 0x96 only bit 0, the modulation enable, is stored, so writing 0xFF reads back 0x01. Any other address reads 0x00 and ignores writes.
- R3: While bit 0 of 0x96 or bit 0 of 0x80 is clear, `susp_n` stays 1.
- R4: When modulation runs, `susp_n` is 0 for idle-count × `TICK_DIV` clocks, then 1 for run-count × `TICK_DIV` clocks, repeating. Over any whole number of periods, the number of clocks with `susp_n`=1 equals the run count × `TICK_DIV` × the number of periods. The request is asserted only at a base-tick boundary.
- R5: A run count of 0 with a non-zero idle count keeps `susp_n` at 0. An idle count of 0 keeps `susp_n` at 1, and this also applies when both counts are 0.
- R6: A count written during a phase does not change that phase's length; it applies from the next phase boundary.
- R7: With 0x80 bit 3 set, a one-clock `irq_evt` pulse drives `susp_n` to 1 by the second clock edge after it. Let N be the reload value in 0x8C. `susp_n` then stays 1 for between (N−1) and N units of `UNIT_TICKS` × `TICK_DIV` clocks. After that, modulation resumes with the R4 duty.
- R8: With 0x80 bit 4 set, `vid_evt` behaves as in R7, using its own reload value from 0x8D.
- R9: An `irq_evt` or `vid_evt` pulse whose enable bit is clear leaves the modulation duty unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the core |

## Verification
The assertions assume that `irq_evt` and `vid_evt` are synchronous to `clk` and that nothing but those pulses starts a hold timer. They also assume that register writes arrive as single-clock strobes away from reset. The stimulus drives every input on the falling edge and holds event pulses for exactly one clock. It waits at least one full period after each change of count before measuring, so every duty window falls in steady state. Hold durations are measured with margin below the shortest legal hold, because the coarse unit phase is free-running.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;

  localparam logic [ADDR_W-1:0] A_PWRCTL  = 8'h80;
  localparam logic [ADDR_W-1:0] A_IRQHOLD = 8'h8C;
  localparam logic [ADDR_W-1:0] A_VIDHOLD = 8'h8D;
  localparam logic [ADDR_W-1:0] A_RUNCNT  = 8'h94;
  localparam logic [ADDR_W-1:0] A_IDLECNT = 8'h95;
  localparam logic [ADDR_W-1:0] A_MODCFG  = 8'h96;

  localparam int B_GLOBAL = 0;
  localparam int B_IRQSPD = 3;
  localparam int B_VIDSPD = 4;

  localparam int N_SRC = 2;

  typedef enum logic {PH_RUN = 1'b0, PH_IDLE = 1'b1} phase_e;

  typedef struct packed {
    logic             glob_en;
    logic             irq_spd_en;
    logic             vid_spd_en;
    logic             mod_en;
    logic [CNT_W-1:0] irq_hold;
    logic [CNT_W-1:0] vid_hold;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] idle_cnt;
  } cfg_t;
endpackage

// File: rtl/sdm_tick_gen.sv
module sdm_tick_gen #(
  parameter int TICK_DIV   = 6400,
  parameter int UNIT_TICKS = 31
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic unit
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int UW = (UNIT_TICKS > 2) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TICK_DIV - 1);
  localparam logic [UW-1:0] U_LAST = UW'(UNIT_TICKS - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [UW-1:0] ucnt_q, ucnt_d;
  logic          tick_c, unit_c;

  always_comb begin
    tick_c = (tcnt_q == T_LAST);
    unit_c = tick_c && (ucnt_q == U_LAST);
    tcnt_d = tick_c ? '0 : tcnt_q + 1'b1;
    ucnt_d = ucnt_q;
    if (tick_c) begin
      ucnt_d = unit_c ? '0 : ucnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      ucnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      ucnt_q <= ucnt_d;
    end
  end

  assign tick = tick_c;
  assign unit = unit_c;
endmodule

// File: rtl/sdm_regs.sv
module sdm_regs
  import sdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output cfg_t              cfg
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      unique case (addr)
        A_PWRCTL: begin
          cfg_d.glob_en    = wr_data[B_GLOBAL];
          cfg_d.irq_spd_en = wr_data[B_IRQSPD];
          cfg_d.vid_spd_en = wr_data[B_VIDSPD];
        end
        A_IRQHOLD: cfg_d.irq_hold = wr_data;
        A_VIDHOLD: cfg_d.vid_hold = wr_data;
        A_RUNCNT:  cfg_d.run_cnt  = wr_data;
        A_IDLECNT: cfg_d.idle_cnt = wr_data;
        A_MODCFG:  cfg_d.mod_en   = wr_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_PWRCTL: begin
        rd_data[B_GLOBAL] = cfg_q.glob_en;
        rd_data[B_IRQSPD] = cfg_q.irq_spd_en;
        rd_data[B_VIDSPD] = cfg_q.vid_spd_en;
      end
      A_IRQHOLD: rd_data = cfg_q.irq_hold;
      A_VIDHOLD: rd_data = cfg_q.vid_hold;
      A_RUNCNT:  rd_data = cfg_q.run_cnt;
      A_IDLECNT: rd_data = cfg_q.idle_cnt;
      A_MODCFG:  rd_data[0] = cfg_q.mod_en;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/sdm_hold_timer.sv
module sdm_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         en,
  input  logic [W-1:0] reload,
  input  logic         unit,
  output logic         active
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (evt && en) begin
      cnt_d = reload;
    end else if (unit && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/sdm_phase_seq.sv
module sdm_phase_seq
  import sdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] run_cnt,
  input  logic [CNT_W-1:0] idle_cnt,
  output logic             susp_n
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             susp_n_q, susp_n_d;
  logic             at_end;

  always_comb begin
    at_end = ({1'b0, cnt_q} + 1'b1) >= {1'b0, len_q};
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    if (!run) begin
      phase_d = PH_RUN;
      cnt_d   = '0;
      len_d   = run_cnt;
    end else if (tick) begin
      if (at_end) begin
        cnt_d = '0;
        if (phase_q == PH_RUN) begin
          if (idle_cnt != '0) begin
            phase_d = PH_IDLE;
            len_d   = idle_cnt;
          end else begin
            phase_d = PH_RUN;
            len_d   = run_cnt;
          end
        end else begin
          if (run_cnt != '0) begin
            phase_d = PH_RUN;
            len_d   = run_cnt;
          end else if (idle_cnt != '0) begin
            phase_d = PH_IDLE;
            len_d   = idle_cnt;
          end else begin
            phase_d = PH_RUN;
            len_d   = '0;
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    susp_n_d = !(run && (phase_q == PH_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_RUN;
      cnt_q    <= '0;
      len_q    <= '0;
      susp_n_q <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
      susp_n_q <= susp_n_d;
    end
  end

  assign susp_n = susp_n_q;
endmodule

// File: rtl/susp_duty_mod.sv
module susp_duty_mod
  import sdm_pkg::*;
#(
  parameter int TICK_DIV   = 6400,
  parameter int UNIT_TICKS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_evt,
  input  logic              vid_evt,
  output logic              susp_n
);
  cfg_t                   cfg;
  logic                   tick;
  logic                   unit;
  logic                   run_cfg;
  logic                   spd_active;
  logic                   run;
  logic [N_SRC-1:0]       src_evt;
  logic [N_SRC-1:0]       src_en;
  logic [N_SRC-1:0][CNT_W-1:0] src_reload;
  logic [N_SRC-1:0]       src_active;

  sdm_tick_gen #(.TICK_DIV(TICK_DIV), .UNIT_TICKS(UNIT_TICKS)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .unit (unit)
  );

  sdm_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .cfg    (cfg)
  );

  assign src_evt    = {vid_evt, irq_evt};
  assign src_en     = {cfg.vid_spd_en, cfg.irq_spd_en};
  assign src_reload = {cfg.vid_hold, cfg.irq_hold};

  for (genvar g = 0; g < N_SRC; g++) begin : g_hold
    sdm_hold_timer #(.W(CNT_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (src_evt[g]),
      .en    (src_en[g]),
      .reload(src_reload[g]),
      .unit  (unit),
      .active(src_active[g])
    );
  end

  assign run_cfg    = cfg.mod_en && cfg.glob_en;
  assign spd_active = |src_active;
  assign run        = run_cfg && !spd_active;

  sdm_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .run_cnt (cfg.run_cnt),
    .idle_cnt(cfg.idle_cnt),
    .susp_n  (susp_n)
  );
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker (
  input logic clk,
  input logic rst_n,
  input logic susp_n,
  input logic run_cfg,
  input logic spd_active,
  input logic tick,
  input logic evt_any
);
  AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_cfg |=> susp_n); // R3

  AST_ASSERT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp_n) |-> $past(tick, 2)); // R4

  AST_SPEEDUP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    spd_active |=> susp_n); // R7

  AST_HOLD_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spd_active) |-> $past(evt_any)); // R8
endmodule

bind susp_duty_mod sdm_checker i_sdm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .susp_n    (susp_n),
  .run_cfg   (run_cfg),
  .spd_active(spd_active),
  .tick      (tick),
  .evt_any   (irq_evt | vid_evt)
);

// File: tb/test_susp_duty_mod.sv
module test_susp_duty_mod;
  localparam int TD = 4;
  localparam int UT = 31;
  localparam int UNITC = TD * UT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_evt = 1'b0;
  logic       vid_evt = 1'b0;
  logic       susp_n;

  always #2.5 clk = ~clk;

  susp_duty_mod #(.TICK_DIV(TD), .UNIT_TICKS(UT)) i_susp_duty_mod (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n)
  );

  typedef struct {
    int    win;
    int    exp;
    string req;
  } item_t;

  item_t q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  int    n_done  = 0;
  int    cyc     = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_val(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected items and counts released cycles over the window
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        int    h;
        it = q.pop_front();
        h = 0;
        for (int i = 0; i < it.win; i++) begin
          if (susp_n) h++;
          @(negedge clk);
        end
        check_val(it.req, h, it.exp);
        n_done++;
      end
    end
  end

  task automatic measure(int win, int exp, string req);
    int    tgt;
    item_t it;
    tgt = n_done + 1;
    it.win = win;
    it.exp = exp;
    it.req = req;
    q.push_back(it);
    wait (n_done == tgt);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, int exp, string req);
    addr = a;
    #1;
    check_val(req, int'(rd_data), exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_irq();
    irq_evt = 1'b1;
    @(negedge clk);
    irq_evt = 1'b0;
  endtask

  task automatic pulse_vid();
    vid_evt = 1'b1;
    @(negedge clk);
    vid_evt = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    int t0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check_val("R1 susp_n", int'(susp_n), 1);
    rd_chk(8'h80, 0, "R1 pwrctl");
    rd_chk(8'h8C, 0, "R1 irqhold");
    rd_chk(8'h8D, 0, "R1 vidhold");
    rd_chk(8'h94, 0, "R1 runcnt");
    rd_chk(8'h95, 0, "R1 idlecnt");
    rd_chk(8'h96, 0, "R1 modcfg");
    @(negedge clk);

    // R2 register port
    wr(8'h80, 8'hFF); rd_chk(8'h80, 8'h19, "R2 pwrctl mask"); @(negedge clk);
    wr(8'h96, 8'hFF); rd_chk(8'h96, 8'h01, "R2 modcfg mask"); @(negedge clk);
    wr(8'h94, 8'd3);  rd_chk(8'h94, 3, "R2 runcnt"); @(negedge clk);
    wr(8'h95, 8'd5);  rd_chk(8'h95, 5, "R2 idlecnt"); @(negedge clk);
    wr(8'h8C, 8'd2);  rd_chk(8'h8C, 2, "R2 irqhold"); @(negedge clk);
    wr(8'h8D, 8'd3);  rd_chk(8'h8D, 3, "R2 vidhold"); @(negedge clk);
    wr(8'h90, 8'hAA); rd_chk(8'h90, 0, "R2 unmapped"); @(negedge clk);
    wr(8'h80, 8'h01);

    // R4 duty: run 3, idle 5
    idle(64);
    measure(3 * 8 * TD, 3 * 3 * TD, "R4 duty 3/5");
    wr(8'h94, 8'd6); wr(8'h95, 8'd2);
    idle(80);
    measure(3 * 8 * TD, 3 * 6 * TD, "R4 duty 6/2");

    // R3 enables
    wr(8'h96, 8'h00); idle(4);
    measure(64, 64, "R3 modcfg clear");
    wr(8'h96, 8'h01); wr(8'h80, 8'h00); idle(4);
    measure(64, 64, "R3 global clear");
    wr(8'h80, 8'h01);

    // R5 zero counts
    wr(8'h94, 8'd0); wr(8'h95, 8'd5); idle(60);
    measure(64, 0, "R5 run zero");
    wr(8'h94, 8'd5); wr(8'h95, 8'd0); idle(80);
    measure(64, 64, "R5 idle zero");

    // R6 new count at next boundary
    wr(8'h94, 8'd2); wr(8'h95, 8'd10);
    while (susp_n) @(negedge clk);
    t0 = cyc;
    wr(8'h95, 8'd1);
    while (!susp_n) @(negedge clk);
    check_val("R6 old idle length kept", cyc - t0, 10 * TD);
    while (susp_n) @(negedge clk);
    t0 = cyc;
    while (!susp_n) @(negedge clk);
    check_val("R6 new idle length", cyc - t0, 1 * TD);

    // R7 interrupt speedup
    wr(8'h94, 8'd1); wr(8'h95, 8'd7);
    wr(8'h80, 8'h09); wr(8'h8C, 8'd2);
    idle(40);
    pulse_irq();
    @(negedge clk);
    check_val("R7 released after irq", int'(susp_n), 1);
    measure(UNITC - 14, UNITC - 14, "R7 hold");
    idle(2 * UNITC);
    measure(3 * 8 * TD, 3 * 1 * TD, "R7 resume duty");

    // R9 events ignored when disabled
    wr(8'h80, 8'h01);
    idle(40);
    pulse_irq();
    measure(3 * 8 * TD, 3 * 1 * TD, "R9 irq ignored");
    pulse_vid();
    measure(3 * 8 * TD, 3 * 1 * TD, "R9 vid ignored");

    // R8 video speedup, reload 3
    wr(8'h80, 8'h11);
    idle(8);
    pulse_vid();
    @(negedge clk);
    check_val("R8 released after vid", int'(susp_n), 1);
    measure(2 * UNITC - 10, 2 * UNITC - 10, "R8 hold");
    idle(2 * UNITC);
    measure(3 * 8 * TD, 3 * 1 * TD, "R8 resume duty");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule